// File: doc/BRIEF.md
# Link Request Serial Encoder

This block sits on the link side of a serial bus node. It turns a request from the link controller into a framed bit stream on a single request line toward the physical-layer device, one bit per clock. A frame opens with a 1 and closes with a 0. Between them it carries a 3-bit request code and, depending on the code, a register address and write data, or a single acceleration flag.

The encoder holds one request at a time. The link offers a request through a valid/ready pair. A write-register or acceleration-control request goes out on the next clock. The four bus requests wait until their timing window opens:
- Fair and priority requests wait until the bus status has shown Idle for more than one clock.
- An isochronous request goes out only within 8 clocks of a transmitted cycle-start or isochronous packet, or within 4 clocks of a received one.
- An immediate request goes out only within 4 clocks of receiving a packet addressed to this node.

If a receive begins while a fair or priority frame is being shifted, the frame is cut off. The whole frame is sent again at the next Idle. A CRC error flagged while an immediate request is held or being shifted withdraws that request.

Top module: `lreq_encoder`

## Requirements
- R1: After reset, `lreq` and `busy` are 0 and `req_ready` is 1.
- R2: Every frame sends bit 0 = 1 (start), then the request code MSB first in bits 1..3, and ends with a 0 stop bit. Codes: 000 immediate, 001 isochronous, 010 priority, 011 fair, 100 register read, 101 register write, 110 acceleration control, 111 reserved. A bus request (codes 000..011) is 5 bits: start, code, stop.
- R3: A register-write frame is 17 bits: bits 4..7 carry the address MSB first, bits 8..15 carry the data MSB first, and bit 16 is the stop bit.
- R4: An acceleration-control frame is 6 bits: bit 4 is the flag (1 enables, 0 disables) and bit 5 is the stop bit.
- R5: `busy` is high for exactly the frame length, from start bit through stop bit. `lreq` is 0 whenever `busy` is low. `req_ready` is low while a request is held or shifting, and a request offered then has no effect.
- R6: A request with code 111 or 100 is refused: `req_drop` pulses for one clock after acceptance and no frame is sent.
- R7: A fair or priority frame starts only on a clock where `ctl_idle` is high and was also high on the previous clock. If Idle rises at clock e, the start bit appears after clock e+1.
- R8: If `ctl_rx` is high while a fair or priority frame is shifting, `busy` and `lreq` drop on the next clock. The request stays held, and the complete frame is sent again once R7 is met.
- R9: An isochronous frame starts only on a clock within 8 clocks of an `ev_tx_cyc` strobe or within 4 clocks of an `ev_rx_cyc` strobe, counting the strobe clock as the first. Outside these windows it waits for the next window.
- R10: An immediate frame starts only on a clock within 4 clocks of an `ev_rx_own` strobe, counting the strobe clock as the first.
- R11: `crc_err` while an immediate request is held or shifting withdraws it. On the next clock `lreq` and `busy` are 0, `req_drop` pulses and `req_ready` returns to 1. The request is never sent.
- R12: Register-write and acceleration-control frames start on the clock after acceptance, with no window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_type | input | 3 | Request code |
| req_addr | input | 4 | Register address for a write |
| req_data | input | 8 | Register data for a write |
| req_accel | input | 1 | Acceleration flag |
| req_ready | output | 1 | Encoder can take a request |
| req_drop | output | 1 | One-clock pulse when a request is refused or withdrawn |
| ctl_idle | input | 1 | Bus status shows Idle |
| ctl_rx | input | 1 | Bus status shows Receive |
| ev_tx_cyc | input | 1 | Strobe: a cycle-start or isochronous packet was transmitted |
| ev_rx_cyc | input | 1 | Strobe: a cycle-start or isochronous packet was received |
| ev_rx_own | input | 1 | Strobe: a packet addressed to this node was received |
| crc_err | input | 1 | Strobe: the received packet has a CRC error |
| lreq | output | 1 | Serial request line |
| busy | output | 1 | A frame is being shifted |

## Verification
A wrong shift counter or frame image changes the bit pattern or the `busy` length on `lreq` within one frame. The bench compares every bit at the clock it is due. A wrong window counter or idle history moves the start bit by one clock. The bench detects this by checking the start clock exactly at the first and last open clock of each window, and one clock past it. A held request that is wrongly cleared or kept shows up as a missing re-send or a stray frame within about twenty clocks.

// File: rtl/lreq_encoder.sv
module lreq_encoder #(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 8,
  parameter int ISO_TX_WIN = 8,
  parameter int ISO_RX_WIN = 4,
  parameter int IMM_WIN    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_type,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic              req_accel,
  output logic              req_ready,
  output logic              req_drop,
  input  logic              ctl_idle,
  input  logic              ctl_rx,
  input  logic              ev_tx_cyc,
  input  logic              ev_rx_cyc,
  input  logic              ev_rx_own,
  input  logic              crc_err,
  output logic              lreq,
  output logic              busy
);
  localparam int FW   = 5 + ADDR_W + DATA_W;
  localparam int CW   = $clog2(FW + 1);
  localparam int WMAX = (ISO_TX_WIN > ISO_RX_WIN) ?
                        ((ISO_TX_WIN > IMM_WIN) ? ISO_TX_WIN : IMM_WIN) :
                        ((ISO_RX_WIN > IMM_WIN) ? ISO_RX_WIN : IMM_WIN);
  localparam int WW   = $clog2(WMAX + 1);
  localparam logic [2:0] T_IMM = 3'd0, T_ISO = 3'd1, T_PRI = 3'd2, T_FAIR = 3'd3,
                         T_RD = 3'd4, T_WR = 3'd5, T_ACC = 3'd6, T_RSV = 3'd7;
  localparam logic [WW-1:0] TX_LOAD  = WW'(ISO_TX_WIN - 1);
  localparam logic [WW-1:0] RX_LOAD  = WW'(ISO_RX_WIN - 1);
  localparam logic [WW-1:0] IMM_LOAD = WW'(IMM_WIN - 1);

  logic              pend, busy_q, lreq_q, idle_q, drop_q;
  logic [2:0]        p_type;
  logic [ADDR_W-1:0] p_addr;
  logic [DATA_W-1:0] p_data;
  logic              p_accel;
  logic [FW-1:0]     sh, frm;
  logic [CW-1:0]     cnt, flen;
  logic [WW-1:0]     iso_win, imm_win, iso_next;
  logic              accept, bad, arb_fair, iso_open, imm_open, can_go;
  logic              start, abort_rx, withdraw;

  assign req_ready = !pend && !busy_q;
  assign accept    = req_valid && req_ready;
  assign bad       = (req_type == T_RSV) || (req_type == T_RD);
  assign arb_fair  = (p_type == T_PRI) || (p_type == T_FAIR);
  assign iso_open  = ev_tx_cyc || ev_rx_cyc || (iso_win != '0);
  assign imm_open  = ev_rx_own || (imm_win != '0);
  assign start     = pend && !busy_q && can_go;
  assign abort_rx  = busy_q && ctl_rx && arb_fair;
  assign withdraw  = pend && (p_type == T_IMM) && crc_err;
  assign lreq      = lreq_q;
  assign busy      = busy_q;
  assign req_drop  = drop_q;

  always_comb begin
    unique case (p_type)
      T_PRI, T_FAIR: can_go = ctl_idle && idle_q && !ctl_rx;
      T_ISO:         can_go = iso_open;
      T_IMM:         can_go = imm_open && !crc_err;
      default:       can_go = 1'b1;
    endcase
  end

  always_comb begin
    frm    = '0;
    frm[0] = 1'b1;
    frm[1] = p_type[2];
    frm[2] = p_type[1];
    frm[3] = p_type[0];
    if (p_type == T_WR) begin
      for (int i = 0; i < ADDR_W; i++) frm[4 + i] = p_addr[ADDR_W - 1 - i];
      for (int i = 0; i < DATA_W; i++) frm[4 + ADDR_W + i] = p_data[DATA_W - 1 - i];
      flen = CW'(FW);
    end else if (p_type == T_ACC) begin
      frm[4] = p_accel;
      flen   = CW'(6);
    end else begin
      flen   = CW'(5);
    end
  end

  always_comb begin
    iso_next = (iso_win != '0) ? iso_win - 1'b1 : '0;
    if (ev_rx_cyc && RX_LOAD > iso_next) iso_next = RX_LOAD;
    if (ev_tx_cyc && TX_LOAD > iso_next) iso_next = TX_LOAD;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend    <= 1'b0;
      busy_q  <= 1'b0;
      lreq_q  <= 1'b0;
      idle_q  <= 1'b0;
      drop_q  <= 1'b0;
      p_type  <= T_WR;
      p_addr  <= '0;
      p_data  <= '0;
      p_accel <= 1'b0;
      sh      <= '0;
      cnt     <= '0;
      iso_win <= '0;
      imm_win <= '0;
    end else begin
      drop_q  <= 1'b0;
      idle_q  <= ctl_idle;
      iso_win <= iso_next;
      if (ev_rx_own)           imm_win <= IMM_LOAD;
      else if (imm_win != '0)  imm_win <= imm_win - 1'b1;
      if (accept) begin
        if (bad) drop_q <= 1'b1;
        else begin
          pend    <= 1'b1;
          p_type  <= req_type;
          p_addr  <= req_addr;
          p_data  <= req_data;
          p_accel <= req_accel;
        end
      end
      if (withdraw) begin
        pend   <= 1'b0;
        busy_q <= 1'b0;
        lreq_q <= 1'b0;
        drop_q <= 1'b1;
      end else if (abort_rx) begin
        busy_q <= 1'b0;
        lreq_q <= 1'b0;
      end else if (start) begin
        busy_q <= 1'b1;
        lreq_q <= frm[0];
        sh     <= frm >> 1;
        cnt    <= flen - 1'b1;
      end else if (busy_q) begin
        if (cnt == '0) begin
          busy_q <= 1'b0;
          lreq_q <= 1'b0;
          pend   <= 1'b0;
        end else begin
          lreq_q <= sh[0];
          sh     <= sh >> 1;
          cnt    <= cnt - 1'b1;
        end
      end
    end
  end

  p_line_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !lreq);
  p_ready_busy_r5: assert property (@(posedge clk) disable iff (!rst_n) busy |-> !req_ready);
  p_start_bit_r2:  assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> lreq);
  p_no_bad_r6:     assert property (@(posedge clk) disable iff (!rst_n)
                     $rose(busy) |-> (p_type != T_RSV) && (p_type != T_RD));
  p_fair_idle_r7:  assert property (@(posedge clk) disable iff (!rst_n)
                     $rose(busy) && arb_fair |-> $past(ctl_idle) && idle_q);
  p_rx_cut_r8:     assert property (@(posedge clk) disable iff (!rst_n)
                     busy && ctl_rx && arb_fair |=> !busy && !req_ready);
  p_crc_drop_r11:  assert property (@(posedge clk) disable iff (!rst_n)
                     crc_err && !req_ready && p_type == T_IMM |=> !busy && req_drop && req_ready);
endmodule

// File: tb/lreq_encoder_test.sv
module lreq_encoder_test;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_accel = 0;
  logic [2:0] req_type = 0;
  logic [3:0] req_addr = 0;
  logic [7:0] req_data = 0;
  logic ctl_idle = 0, ctl_rx = 0, ev_tx_cyc = 0, ev_rx_cyc = 0, ev_rx_own = 0, crc_err = 0;
  logic req_ready, req_drop, lreq, busy;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  lreq_encoder uut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [16:0] mk(input logic [2:0] t, input logic [3:0] a,
                                     input logic [7:0] d, input logic f, input int len);
    logic [16:0] b = '0;
    b[0] = 1; b[1] = t[2]; b[2] = t[1]; b[3] = t[0];
    if (len == 17) begin
      for (int i = 0; i < 4; i++) b[4 + i] = a[3 - i];
      for (int i = 0; i < 8; i++) b[8 + i] = d[7 - i];
    end else if (len == 6) b[4] = f;
    return b;
  endfunction

  task automatic submit(input logic [2:0] t, input logic [3:0] a, input logic [7:0] d, input logic f);
    req_valid = 1; req_type = t; req_addr = a; req_data = d; req_accel = f;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic frame(input logic [16:0] b, input int len, input string tag);
    int bad = 0, pos = -1;
    for (int i = 0; i < len; i++) begin
      if (lreq !== b[i] || busy !== 1'b1) begin
        if (pos < 0) pos = i;
        bad++;
      end
      @(negedge clk);
    end
    chk(bad == 0, {tag, " frame bits"}, pos, -1);
    chk(busy === 0 && lreq === 0, {tag, " busy ends after stop"}, busy, 0);
  endtask

  task automatic quiet(input int n, input string tag);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      if (lreq !== 0 || busy !== 0) seen++;
      @(negedge clk);
    end
    chk(seen == 0, tag, seen, 0);
  endtask

  task automatic t_reset;
    chk(lreq === 0 && busy === 0 && req_ready === 1, "R1 reset state", {lreq, busy, req_ready}, 1);
  endtask

  task automatic t_write;
    submit(3'b101, 4'hA, 8'h5C, 0);
    chk(lreq === 0, "R12 no start on accept clock", lreq, 0);
    tick(1);
    chk(lreq === 1, "R12 start one clock after accept", lreq, 1);
    frame(mk(3'b101, 4'hA, 8'h5C, 0, 17), 17, "R3 R2 R5 write");
    chk(req_ready === 1, "R5 ready after frame", req_ready, 1);
  endtask

  task automatic t_accel;
    submit(3'b110, 0, 0, 1); tick(1);
    frame(mk(3'b110, 0, 0, 1, 6), 6, "R4 accel on");
    submit(3'b110, 0, 0, 0); tick(1);
    frame(mk(3'b110, 0, 0, 0, 6), 6, "R4 accel off");
  endtask

  task automatic t_refuse;
    submit(3'b111, 0, 0, 0);
    chk(req_drop === 1, "R6 reserved drop pulse", req_drop, 1);
    quiet(15, "R6 reserved not sent");
    submit(3'b100, 0, 0, 0);
    chk(req_drop === 1, "R6 read drop pulse", req_drop, 1);
    quiet(15, "R6 read not sent");
    chk(req_ready === 1, "R6 ready after refusal", req_ready, 1);
  endtask

  task automatic t_fair;
    ctl_idle = 0;
    submit(3'b011, 0, 0, 0);
    quiet(6, "R7 fair waits for idle");
    ctl_idle = 1;
    tick(1);
    chk(lreq === 0, "R7 no start on first idle clock", lreq, 0);
    tick(1);
    chk(lreq === 1, "R7 start after second idle clock", lreq, 1);
    frame(mk(3'b011, 0, 0, 0, 5), 5, "R7 R2 fair");
  endtask

  task automatic t_abort;
    submit(3'b010, 0, 0, 0);
    tick(1);
    chk(lreq === 1, "R7 priority starts with idle held", lreq, 1);
    tick(1);
    ctl_rx = 1; ctl_idle = 0;
    tick(1);
    chk(busy === 0 && lreq === 0, "R8 frame cut by receive", busy, 0);
    chk(req_ready === 0, "R8 request kept", req_ready, 0);
    quiet(3, "R8 silent during receive");
    ctl_rx = 0; ctl_idle = 1;
    tick(2);
    chk(lreq === 1, "R8 resend at next idle", lreq, 1);
    frame(mk(3'b010, 0, 0, 0, 5), 5, "R8 priority resend");
  endtask

  task automatic t_iso;
    ev_rx_cyc = 1; tick(1); ev_rx_cyc = 0;
    tick(1);
    submit(3'b001, 0, 0, 0);
    chk(lreq === 0, "R9 iso not yet", lreq, 0);
    tick(1);
    chk(lreq === 1, "R9 iso at last rx window clock", lreq, 1);
    frame(mk(3'b001, 0, 0, 0, 5), 5, "R9 iso rx");
    ev_rx_cyc = 1; tick(1); ev_rx_cyc = 0;
    tick(2);
    submit(3'b001, 0, 0, 0);
    quiet(10, "R9 iso held past rx window");
    ev_tx_cyc = 1; tick(1); ev_tx_cyc = 0;
    chk(lreq === 1, "R9 iso on tx strobe clock", lreq, 1);
    frame(mk(3'b001, 0, 0, 0, 5), 5, "R9 iso tx strobe");
    ev_tx_cyc = 1; tick(1); ev_tx_cyc = 0;
    tick(5);
    submit(3'b001, 0, 0, 0);
    tick(1);
    chk(lreq === 1, "R9 iso at last tx window clock", lreq, 1);
    frame(mk(3'b001, 0, 0, 0, 5), 5, "R9 iso tx");
    ev_tx_cyc = 1; tick(1); ev_tx_cyc = 0;
    tick(6);
    submit(3'b001, 0, 0, 0);
    quiet(6, "R9 iso held past tx window");
    ev_rx_cyc = 1; tick(1); ev_rx_cyc = 0;
    frame(mk(3'b001, 0, 0, 0, 5), 5, "R9 iso after rx strobe");
  endtask

  task automatic t_imm;
    ev_rx_own = 1; tick(1); ev_rx_own = 0;
    tick(1);
    submit(3'b000, 0, 0, 0);
    tick(1);
    chk(lreq === 1, "R10 imm at last window clock", lreq, 1);
    frame(mk(3'b000, 0, 0, 0, 5), 5, "R10 imm");
    submit(3'b000, 0, 0, 0);
    quiet(4, "R10 imm waits for window");
    crc_err = 1; tick(1); crc_err = 0;
    chk(req_drop === 1 && req_ready === 1, "R11 held imm withdrawn", {req_drop, req_ready}, 3);
    ev_rx_own = 1; tick(1); ev_rx_own = 0;
    quiet(8, "R11 withdrawn imm never sent");
    submit(3'b000, 0, 0, 0);
    ev_rx_own = 1; tick(1); ev_rx_own = 0;
    chk(lreq === 1, "R10 imm on strobe clock", lreq, 1);
    crc_err = 1; tick(1); crc_err = 0;
    chk(busy === 0 && lreq === 0 && req_drop === 1, "R11 shifting imm cut", {busy, lreq, req_drop}, 1);
    quiet(8, "R11 cut imm not resent");
  endtask

  task automatic t_ignore;
    submit(3'b101, 4'h3, 8'hC1, 0);
    req_valid = 1; req_type = 3'b110; req_accel = 1;
    tick(1);
    frame(mk(3'b101, 4'h3, 8'hC1, 0, 17), 17, "R5 write while offered");
    req_valid = 0;
    quiet(20, "R5 request offered while busy ignored");
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);
    t_reset;
    t_write;
    t_accel;
    t_refuse;
    t_fair;
    t_abort;
    t_iso;
    t_imm;
    t_ignore;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule